// File: doc/BRIEF.md
# Flash-Side Serial Link Byte Engine

This block is the flash end of a three-wire camera link: a bidirectional open-drain data line, an open-drain clock line that the flash drives, and a handshake line that the camera drives low to open each byte. The block never drives a line high. It pulls a line low through an output-enable, and the external pull-up provides the high level. A frame begins with a negotiation step. The camera pulses data low, the engine answers by holding data low, and the camera then lowers the handshake. The engine releases data, waits a settling time, and clocks the first byte in. Every later byte of the same frame starts as soon as the handshake falls again.

The frame layer above the engine chooses the direction of each later byte, supplies the byte to send, and signals when a frame is complete. Between frames, the engine can hold the clock low to acknowledge a strobe. After an external trigger it can also hold data low for a programmable number of cycles. All timing is set by parameters in system-clock cycles. The line inputs pass through `SYNC_STAGES` synchronizing flops before any decision is made on them.

Top module: `flink_engine`

## Requirements
- R1: After reset, data_oe_o, clk_oe_o, rx_valid_o, tx_take_o and abort_o are all 0 while strobe_ack_i is low.
- R2: In idle, a low level on the data line makes the engine drive data low (data_oe_o=1) and keep it there, with clk_oe_o=0, until the handshake line goes low.
- R3: For the first byte of a frame, clk_oe_o first rises SYNC_STAGES+1+SETTLE_CYC cycles after the handshake falls, with data released in that window. The first byte is always received, whatever dir_tx_i says: no data drive and no tx_take_o.
- R4: Each byte consists of 8 clock periods of BIT_CYC cycles. clk_oe_o is 1 (line low) for the first BIT_CYC/2 cycles of each period.
- R5: Received bits are sampled while the clock line is high, most significant bit first. After the last period, rx_valid_o pulses for one cycle with the byte on rx_byte_o.
- R6: When dir_tx_i=1 at the start of a later byte, tx_byte_i is taken and tx_take_o pulses. Data is driven low for each 0 bit and released for each 1 bit, most significant bit first. The driven value changes only when clk_oe_o rises, and no rx_valid_o pulse follows.
- R7: Later bytes of a frame need no data negotiation. clk_oe_o rises SYNC_STAGES+1 cycles after the handshake falls, and data is not driven beforehand. The handshake returns high between bytes.
- R8: If the handshake rises during settling or clocking, clocking stops, both output-enables are released, abort_o pulses, and the engine returns to idle. A later handshake without a data poll produces no clock.
- R9: A frame_end_i pulse between bytes returns the engine to idle. A later handshake then produces no clock until a new poll.
- R10: In idle, clk_oe_o follows strobe_ack_i for as long as it is held.
- R11: A trig_i pulse in idle drives data low for exactly hold_len_i cycles, and a length of 0 drives nothing. The release of that hold is not mistaken for a poll.
- R12: trig_i outside idle has no effect on the data line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| data_line_i | input | 1 | Sensed level of the data line |
| hs_line_n_i | input | 1 | Sensed level of the handshake line, active low |
| dir_tx_i | input | 1 | 1: next later byte is sent by the flash |
| tx_byte_i | input | DATA_W | Byte to send, taken at byte start |
| frame_end_i | input | 1 | Pulse: frame complete, next byte needs negotiation |
| strobe_ack_i | input | 1 | Hold the clock line low while idle |
| trig_i | input | 1 | Pulse: start the post-trigger data hold |
| hold_len_i | input | HOLD_W | Length of the data hold in cycles |
| data_oe_o | output | 1 | Pull data line low |
| clk_oe_o | output | 1 | Pull clock line low |
| rx_valid_o | output | 1 | One-cycle pulse: rx_byte_o holds a received byte |
| rx_byte_o | output | DATA_W | Received byte |
| tx_take_o | output | 1 | One-cycle pulse: tx_byte_i was taken |
| abort_o | output | 1 | One-cycle pulse: byte cut short by the handshake |

## Verification
The bench measures the gap from the handshake edge to the first clock edge. It does this both for the first byte and for later bytes, so a design that settles on every byte, or never settles, shows the wrong latency. It sets dir_tx_i high on first bytes, and releases the handshake in the middle of a byte that drives all zeros. A design that obeys the direction pin too early would drive the data line. A design that keeps clocking or keeps pulling data after the handshake rises would be caught by the abort check. The bench also ends a data hold and ends an aborted byte while the synchronized data level is still low. An engine without blanking would read its own released drive as a camera poll and start a spurious negotiation.

// File: rtl/flink_pkg.sv
package flink_pkg;
   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_NEG    = 3'd1,
      S_SETTLE = 3'd2,
      S_BITS   = 3'd3,
      S_GAP    = 3'd4,
      S_MID    = 3'd5
   } link_st_e;
endpackage

// File: rtl/flink_sync.sv
module flink_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {STAGES{RST_VAL}};
            else if (STAGES == 1) pipe <= d;
            else pipe <= {pipe[STAGES-2:0], d};
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/flink_hold.sv
module flink_hold #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] len,
   output logic         active
);
   logic [W-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) left <= '0;
      else if (start) left <= len;
      else if (left != '0) left <= left - W'(1);
   end

   assign active = (left != '0);
endmodule

// File: rtl/flink_shift.sv
module flink_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] ld_val,
   input  logic         shift_en,
   input  logic         s_in,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= ld_val;
      else if (shift_en) q <= {q[W-2:0], s_in};
   end
endmodule

// File: rtl/flink_engine.sv
module flink_engine
   import flink_pkg::*;
#(
   parameter int BIT_CYC     = 3200,
   parameter int SETTLE_CYC  = 400,
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_W      = 20,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_line_i,
   input  logic              hs_line_n_i,
   input  logic              dir_tx_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              frame_end_i,
   input  logic              strobe_ack_i,
   input  logic              trig_i,
   input  logic [HOLD_W-1:0] hold_len_i,
   output logic              data_oe_o,
   output logic              clk_oe_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              tx_take_o,
   output logic              abort_o
);
   localparam int HALF    = BIT_CYC / 2;
   localparam int CNT_MAX = (BIT_CYC > SETTLE_CYC) ? BIT_CYC : SETTLE_CYC;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam int IDX_W   = $clog2(DATA_W);
   localparam int BLANK   = SYNC_STAGES + 1;
   localparam int BLANK_W = $clog2(BLANK + 1);

   generate
      if (BIT_CYC < 4 || (BIT_CYC % 2) != 0) begin : g_bad_bit
         $error("BIT_CYC must be even and at least 4");
      end
      if (HALF <= SYNC_STAGES + 1) begin : g_bad_half
         $error("half bit period must exceed the synchronizer latency");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (DATA_W < 2 || HOLD_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 2 and HOLD_W at least 1");
      end
   endgenerate

   link_st_e            st;
   logic [CNT_W-1:0]    cnt;
   logic [IDX_W-1:0]    bitn;
   logic [BLANK_W-1:0]  blank;
   logic                tx_mode;
   logic                rx_valid_q, tx_take_q, abort_q;
   logic                data_s, hs_s;
   logic                hold_active, hold_start;
   logic                poll;
   logic                sh_load, sh_shift, sh_in;
   logic [DATA_W-1:0]   sh_q;
   logic                data_oe, clk_oe;
   logic                last_cyc;

   flink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .d(data_line_i), .q(data_s));

   flink_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_hs (
      .clk(clk), .rst_n(rst_n), .d(hs_line_n_i), .q(hs_s));

   assign hold_start = trig_i && (st == S_IDLE);

   flink_hold #(.W(HOLD_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(hold_start), .len(hold_len_i),
      .active(hold_active));

   // one register serves both directions: loaded for send, filled for receive
   assign last_cyc = (cnt == CNT_W'(BIT_CYC - 1));
   assign sh_load  = (st == S_MID) && !hs_s && !frame_end_i;
   assign sh_shift = (st == S_BITS) && !hs_s &&
                     ((tx_mode && last_cyc) || (!tx_mode && cnt == CNT_W'(HALF)));
   assign sh_in    = tx_mode ? 1'b0 : data_s;

   flink_shift #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .ld_val(tx_byte_i),
      .shift_en(sh_shift), .s_in(sh_in), .q(sh_q));

   // a poll is only believed once the synchronizer no longer shows our own drive
   assign poll = !data_s && (blank == '0) && !hold_active && !trig_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         cnt        <= '0;
         bitn       <= '0;
         tx_mode    <= 1'b0;
         rx_valid_q <= 1'b0;
         tx_take_q  <= 1'b0;
         abort_q    <= 1'b0;
         blank      <= BLANK_W'(BLANK);
      end else begin
         rx_valid_q <= 1'b0;
         tx_take_q  <= 1'b0;
         abort_q    <= 1'b0;

         if (data_oe || st != S_IDLE) blank <= BLANK_W'(BLANK);
         else if (blank != '0) blank <= blank - BLANK_W'(1);

         unique case (st)
            S_IDLE: begin
               if (poll) st <= S_NEG;
            end
            S_NEG: begin
               if (!hs_s) begin
                  st  <= S_SETTLE;
                  cnt <= '0;
               end
            end
            S_SETTLE: begin
               if (hs_s) begin
                  st      <= S_IDLE;
                  abort_q <= 1'b1;
               end else if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
                  st      <= S_BITS;
                  cnt     <= '0;
                  bitn    <= '0;
                  tx_mode <= 1'b0;
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            S_BITS: begin
               if (hs_s) begin
                  st      <= S_IDLE;
                  abort_q <= 1'b1;
               end else if (last_cyc) begin
                  cnt <= '0;
                  if (bitn == IDX_W'(DATA_W - 1)) begin
                     st         <= S_GAP;
                     rx_valid_q <= !tx_mode;
                  end else begin
                     bitn <= bitn + IDX_W'(1);
                  end
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
            end
            S_GAP: begin
               if (frame_end_i) st <= S_IDLE;
               else if (hs_s) st <= S_MID;
            end
            S_MID: begin
               if (frame_end_i) begin
                  st <= S_IDLE;
               end else if (!hs_s) begin
                  st        <= S_BITS;
                  cnt       <= '0;
                  bitn      <= '0;
                  tx_mode   <= dir_tx_i;
                  tx_take_q <= dir_tx_i;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign clk_oe  = ((st == S_BITS) && (cnt < CNT_W'(HALF))) ||
                    ((st == S_IDLE) && strobe_ack_i);
   assign data_oe = (st == S_NEG) ||
                    ((st == S_BITS) && tx_mode && !sh_q[DATA_W-1]) ||
                    hold_active;

   assign data_oe_o  = data_oe;
   assign clk_oe_o   = clk_oe;
   assign rx_valid_o = rx_valid_q;
   assign rx_byte_o  = sh_q;
   assign tx_take_o  = tx_take_q;
   assign abort_o    = abort_q;
endmodule

// File: rtl/flink_engine_chk.sv
module flink_engine_chk
   import flink_pkg::*;
(
   input logic     clk,
   input logic     rst_n,
   input link_st_e st,
   input logic     tx_mode,
   input logic     data_oe_o,
   input logic     clk_oe_o,
   input logic     strobe_ack_i,
   input logic     rx_valid_o,
   input logic     tx_take_o,
   input logic     abort_o
);
   // R2
   neg_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_NEG) |-> (data_oe_o && !clk_oe_o));

   // R5
   rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BITS && !tx_mode) |-> !data_oe_o);

   // R5
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> ($past(st) == S_BITS && st == S_GAP));

   // R6
   tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_BITS && $past(st) == S_BITS && tx_mode && !$rose(clk_oe_o))
         |-> $stable(data_oe_o));

   // R6
   tx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_take_o |-> (tx_mode && st == S_BITS && clk_oe_o));

   // R8
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (!data_oe_o && (clk_oe_o == strobe_ack_i)));
endmodule

bind flink_engine flink_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .tx_mode(tx_mode),
   .data_oe_o(data_oe_o), .clk_oe_o(clk_oe_o), .strobe_ack_i(strobe_ack_i),
   .rx_valid_o(rx_valid_o), .tx_take_o(tx_take_o), .abort_o(abort_o));

// File: tb/flink_engine_bench.sv
module flink_engine_bench;
   localparam int BIT   = 8;
   localparam int SET   = 4;
   localparam int SYN   = 2;
   localparam int HW    = 8;
   localparam int DW    = 8;
   localparam int HALFB = BIT / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cam_dl = 1'b0;
   logic hs_n = 1'b1;
   logic dir_tx = 1'b0;
   logic [DW-1:0] tx_byte = '0;
   logic frame_end = 1'b0;
   logic strobe_ack = 1'b0;
   logic trig = 1'b0;
   logic [HW-1:0] hold_len = '0;
   logic data_oe, clk_oe, rx_valid, tx_take, abort_p;
   logic [DW-1:0] rx_byte;
   logic data_line;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 0;

   always #5 clk = ~clk;

   assign data_line = !(data_oe || cam_dl);

   flink_engine #(.BIT_CYC(BIT), .SETTLE_CYC(SET), .SYNC_STAGES(SYN),
                  .HOLD_W(HW), .DATA_W(DW)) u_flink_engine (
      .clk(clk), .rst_n(rst_n), .data_line_i(data_line), .hs_line_n_i(hs_n),
      .dir_tx_i(dir_tx), .tx_byte_i(tx_byte), .frame_end_i(frame_end),
      .strobe_ack_i(strobe_ack), .trig_i(trig), .hold_len_i(hold_len),
      .data_oe_o(data_oe), .clk_oe_o(clk_oe), .rx_valid_o(rx_valid),
      .rx_byte_o(rx_byte), .tx_take_o(tx_take), .abort_o(abort_p));

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got %0d cycles expected < 150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   function automatic int exp_lat(input bit first);
      return SYN + 1 + (first ? SET : 0);
   endfunction

   function automatic int exp_low_cycles();
      return DW * HALFB;
   endfunction

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic poll_start;
      int g = 0;
      cam_dl = 1'b1;
      while (!data_oe && g < 60) begin tick; g++; end
      chk(data_oe == 1'b1, "R2", "drive after poll", data_oe, 1);
      cam_dl = 1'b0;
      repeat (5) tick;
      chk(data_oe && !clk_oe, "R2", "data held, no clock, until handshake",
          {data_oe, clk_oe}, 2);
   endtask

   task automatic do_byte(input bit first, input bit tx, input logic [DW-1:0] cam_b,
                          input logic [DW-1:0] fl_b, input bit dir_pin);
      int lat = 0;
      int falls = 0;
      int lowc = 0;
      int g = 0;
      bit eff_tx, prev, cur, pre_drv, saw_drv, saw_take, saw_valid;
      logic [DW-1:0] got = '0;
      logic [DW-1:0] vbyte = '0;
      string rq;
      eff_tx = tx && !first;
      dir_tx = first ? dir_pin : tx;
      tx_byte = fl_b;
      pre_drv = 0; saw_drv = 0; saw_take = 0; saw_valid = 0;
      rq = first ? "R3" : "R7";
      if (first) poll_start();
      else chk(data_oe == 1'b0, "R7", "no data drive before later byte", data_oe, 0);
      hs_n = 1'b0;
      do begin
         tick;
         lat++;
         if (!first && data_oe && !clk_oe) pre_drv = 1;
      end while (!clk_oe && lat < 200);
      chk(lat == exp_lat(first), rq, "handshake to clock latency", lat, exp_lat(first));
      if (!first) chk(!pre_drv, "R7", "no negotiation drive", pre_drv, 0);
      cam_dl = !eff_tx && !cam_b[DW-1];
      prev = 1'b0;
      while (falls < DW && g < 500) begin
         cur = clk_oe;
         if (cur) lowc++;
         if (data_oe && !eff_tx) saw_drv = 1;
         if (tx_take) saw_take = 1;
         if (prev && !cur) begin
            got = {got[DW-2:0], data_line};
            falls++;
         end
         if (!prev && cur && falls > 0 && falls < DW) cam_dl = !eff_tx && !cam_b[DW-1-falls];
         prev = cur;
         if (falls < DW) begin tick; g++; end
      end
      cam_dl = 1'b0;
      for (int k = 0; k < 2 * HALFB; k++) begin
         tick;
         if (rx_valid) begin saw_valid = 1; vbyte = rx_byte; end
      end
      chk(lowc == exp_low_cycles(), "R4", "clock-low cycles per byte", lowc, exp_low_cycles());
      if (eff_tx) begin
         chk(got == fl_b, "R6", "sent byte on line", got, fl_b);
         chk(saw_take, "R6", "tx_take pulse", saw_take, 1);
         chk(!saw_valid, "R6", "no rx_valid on send", saw_valid, 0);
      end else begin
         chk(saw_valid && vbyte == cam_b, "R5", "received byte", vbyte, cam_b);
         chk(!saw_drv && !saw_take, first ? "R3" : "R5", "receive drives no data",
             {saw_drv, saw_take}, 0);
      end
      hs_n = 1'b1;
      repeat (SYN + 2) tick;
   endtask

   task automatic end_frame;
      frame_end = 1'b1;
      tick;
      frame_end = 1'b0;
      tick;
   endtask

   task automatic no_clock_window(input string req, input int n);
      bit seen = 0;
      hs_n = 1'b0;
      repeat (n) begin tick; if (clk_oe || data_oe) seen = 1; end
      chk(!seen, req, "handshake without poll gives no activity", seen, 0);
      hs_n = 1'b1;
      repeat (SYN + 3) tick;
   endtask

   initial begin
      int nb, hl, n;
      bit seen, ok;
      void'($urandom(32'd4242));
      repeat (3) tick;
      // R1
      chk(!data_oe && !clk_oe && !rx_valid && !tx_take && !abort_p, "R1",
          "outputs in reset", {data_oe, clk_oe, rx_valid, tx_take, abort_p}, 0);
      rst_n = 1'b1;
      repeat (4) tick;
      chk(!data_oe && !clk_oe && !rx_valid && !tx_take && !abort_p, "R1",
          "outputs after reset", {data_oe, clk_oe, rx_valid, tx_take, abort_p}, 0);

      // directed: first byte with direction pin high still receives (R3)
      do_byte(1'b1, 1'b0, 8'hA5, 8'h00, 1'b1);
      do_byte(1'b0, 1'b1, 8'h00, 8'h3C, 1'b1);
      do_byte(1'b0, 1'b0, 8'h81, 8'h00, 1'b0);
      // R12: trigger between bytes ignored
      hold_len = 8'd20;
      trig = 1'b1; tick; trig = 1'b0;
      seen = 0;
      repeat (25) begin tick; if (data_oe) seen = 1; end
      chk(!seen, "R12", "trigger outside idle", seen, 0);
      do_byte(1'b0, 1'b1, 8'h00, 8'hFE, 1'b1);
      end_frame();

      // R9: frame_end between bytes drops back to idle
      do_byte(1'b1, 1'b0, 8'h5A, 8'h00, 1'b0);
      end_frame();
      no_clock_window("R9", 30);

      // R8: abort mid-byte while sending zeros
      do_byte(1'b1, 1'b0, 8'hC3, 8'h00, 1'b0);
      dir_tx = 1'b1; tx_byte = 8'h00;
      hs_n = 1'b0;
      n = 0; seen = 0;
      while (n < 3 && seen == 0) begin
         tick;
         if (!clk_oe && data_oe) seen = 1;
         if (seen) n = 3;
      end
      repeat (2 * BIT) tick;
      hs_n = 1'b1;
      seen = 0;
      for (int k = 0; k < 10; k++) begin
         tick;
         if (abort_p) seen = 1;
      end
      chk(seen, "R8", "abort pulse", seen, 1);
      chk(!clk_oe && !data_oe, "R8", "lines released after abort", {clk_oe, data_oe}, 0);
      no_clock_window("R8", 30);

      // R10: strobe acknowledge in idle
      n = 5 + int'($urandom_range(35));
      strobe_ack = 1'b1;
      #1;
      ok = clk_oe;
      repeat (n) begin tick; if (!clk_oe) ok = 0; end
      chk(ok, "R10", "clock held for strobe", ok, 1);
      strobe_ack = 1'b0;
      #1;
      chk(!clk_oe, "R10", "clock released after strobe", clk_oe, 0);
      tick;

      // R11: trigger hold, random lengths and zero
      for (int t = 0; t < 6; t++) begin
         hl = (t == 0) ? 1 : ((t == 1) ? 0 : 1 + int'($urandom_range(59)));
         hold_len = HW'(hl);
         trig = 1'b1; tick; trig = 1'b0;
         n = 0;
         while (data_oe && n < 300) begin n++; tick; end
         chk(n == hl, "R11", "hold length", n, hl);
         seen = 0;
         repeat (12) begin tick; if (data_oe || clk_oe) seen = 1; end
         chk(!seen, "R11", "release not taken as poll", seen, 0);
      end

      // random frames
      for (int f = 0; f < 30; f++) begin
         nb = 1 + int'($urandom_range(4));
         for (int b = 0; b < nb; b++) begin
            do_byte(b == 0, 1'($urandom_range(1)), 8'($urandom), 8'($urandom),
                    1'($urandom_range(1)));
         end
         end_frame();
         repeat (int'($urandom_range(10))) tick;
      end

      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end
endmodule